// File: doc/BRIEF.md
# Memory Access Watchpoint Interrupt Unit

This block watches three memory access ports: an instruction-side tightly coupled memory (port 0), a data-side tightly coupled memory (port 1) and an on-chip RAM (port 2). Each port has its own programmable watch address. It also has a direction bit that chooses whether a read or a write to that address counts as a hit. Each port also reports access errors. Hits and errors are events. Each event can be latched into a sticky status register, and only events enabled by a latch mask are latched. A second mask decides which latched bits drive a single registered, active-high interrupt line.

Software reaches the block through a small word-addressed register interface with one-cycle read data. The same interface holds a control word. Its three bits are exported to the memory subsystem: write wait mode, read wait mode and forced RAM clock.

Top module: `mem_watch_irq`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and `wr_wait`, `rd_wait` and `clk_force` are low.
- R2: Registers are selected by `reg_addr`: 0 status, 1 latch mask, 2 interrupt mask, 3 control, 4/5/6 watch register of port 0/1/2. A read (valid with write low) presents its data on `reg_rdata` after the next clock edge. Bits with no storage read as zero.
- R3: A watch register keeps the direction select in bit 0 and a 14-bit word address in bits 14:1.
- R4: With select 0, a qualified read whose address equals the watch address raises the port's hit event. A write to that address raises nothing.
- R5: With select 1, a qualified write to the watch address raises the hit event. A read to that address raises nothing.
- R6: An access with a different address, or one without `acc_valid`, raises no event.
- R7: `acc_err` of port p raises event bit 3+p. The hit of port p is event bit p.
- R8: An event sets its status bit only when the same bit of the latch mask is 1.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 has no effect. If an event and a clear land on the same bit in the same cycle, the bit stays set.
- R10: One cycle after `status & interrupt_mask` becomes nonzero, `irq` is high. One cycle after it becomes zero, `irq` is low.
- R11: Control bit 0 drives `wr_wait`, bit 1 drives `rd_wait` and bit 2 drives `clk_force`.
- R12: An event on one port sets only that port's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| acc_valid | input | 3 | Per-port access strobe |
| acc_write | input | 3 | Per-port access direction, 1 = write |
| acc_addr | input | 42 | Per-port 14-bit word address, port p at bits 14p+13:14p |
| acc_err | input | 3 | Per-port access error pulse |
| irq | output | 1 | Registered interrupt, active high |
| wr_wait | output | 1 | Write wait mode (two-cycle writes) |
| rd_wait | output | 1 | Read wait mode (two-cycle reads) |
| clk_force | output | 1 | Force RAM clock on |

## Verification
Four properties are checked on every cycle. A status bit never rises unless the latch mask allowed it in the previous cycle. A status bit falls only after a one-write to the status register. The interrupt line follows the masked status with one cycle of lag. Read data never shows bits above the watch-register width. Only the directed scenarios can show that the address comparison, the read/write select, the per-port bit assignment, the rule that a simultaneous set wins over a clear, and the control outputs behave as specified.

// File: rtl/mem_watch_irq.sv
module mem_watch_irq #(
  parameter int AW  = 14,
  parameter int NP  = 3,
  parameter int DW  = 32,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_valid,
  input  logic           reg_write,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [NP-1:0]  acc_valid,
  input  logic [NP-1:0]  acc_write,
  input  logic [NP*AW-1:0] acc_addr,
  input  logic [NP-1:0]  acc_err,
  output logic           irq,
  output logic           wr_wait,
  output logic           rd_wait,
  output logic           clk_force
);
  localparam int NEV = 2 * NP;
  localparam int MW  = AW + 1;
  localparam logic [RAW-1:0] A_STAT = RAW'(0);
  localparam logic [RAW-1:0] A_LEN  = RAW'(1);
  localparam logic [RAW-1:0] A_IEN  = RAW'(2);
  localparam logic [RAW-1:0] A_CTRL = RAW'(3);
  localparam int A_WATCH0 = 4;

  logic [NEV-1:0] status_q, len_q, ien_q, events, clr;
  logic [2:0]     ctrl_q;
  logic [MW-1:0]  watch_q [NP];
  logic [NP-1:0]  hit;
  logic [DW-1:0]  rd_mux;
  logic           wr_en;

  assign wr_en = reg_valid && reg_write;

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign hit[p] = acc_valid[p] && (acc_write[p] == watch_q[p][0])
                    && (acc_addr[p*AW +: AW] == watch_q[p][MW-1:1]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) watch_q[p] <= '0;
      else if (wr_en && reg_addr == RAW'(A_WATCH0 + p)) watch_q[p] <= reg_wdata[MW-1:0];
  end

  assign events = {acc_err, hit};
  assign clr    = (wr_en && reg_addr == A_STAT) ? reg_wdata[NEV-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      len_q    <= '0;
      ien_q    <= '0;
      ctrl_q   <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | (events & len_q);
      irq      <= |(status_q & ien_q);
      if (wr_en && reg_addr == A_LEN)  len_q  <= reg_wdata[NEV-1:0];
      if (wr_en && reg_addr == A_IEN)  ien_q  <= reg_wdata[NEV-1:0];
      if (wr_en && reg_addr == A_CTRL) ctrl_q <= reg_wdata[2:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_STAT:  rd_mux[NEV-1:0] = status_q;
      A_LEN:   rd_mux[NEV-1:0] = len_q;
      A_IEN:   rd_mux[NEV-1:0] = ien_q;
      A_CTRL:  rd_mux[2:0]     = ctrl_q;
      default: begin
        for (int p = 0; p < NP; p++)
          if (reg_addr == RAW'(A_WATCH0 + p)) rd_mux[MW-1:0] = watch_q[p];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg_rdata <= '0;
    else if (reg_valid && !reg_write) reg_rdata <= rd_mux;

  assign wr_wait   = ctrl_q[0];
  assign rd_wait   = ctrl_q[1];
  assign clk_force = ctrl_q[2];

  // R8
  latch_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(len_q)) == '0));

  for (genvar b = 0; b < NEV; b++) begin : g_chk
    // R9
    clear_only_by_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_q[b]) |-> $past(wr_en && reg_addr == A_STAT && reg_wdata[b]));
  end

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & ien_q)) |=> irq);

  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_q & ien_q)) |=> !irq);

  // R2
  rdata_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:MW] == '0);
endmodule

// File: tb/test_mem_watch_irq.sv
module test_mem_watch_irq;
  logic        clk = 0, rst_n = 0;
  logic        reg_valid = 0, reg_write = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [2:0]  acc_valid = 0, acc_write = 0, acc_err = 0;
  logic [41:0] acc_addr = 0;
  logic        irq, wr_wait, rd_wait, clk_force;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mem_watch_irq i_mem_watch_irq (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_valid = 1; reg_write = 0; reg_addr = a;
    @(posedge clk); @(negedge clk); reg_valid = 0; d = reg_rdata;
  endtask

  task automatic access(int p, logic v, logic w, logic [13:0] a, logic e);
    @(negedge clk);
    acc_valid[p] = v; acc_write[p] = w; acc_addr[p*14 +: 14] = a; acc_err[p] = e;
    @(posedge clk); @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_err = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d); chk("R1 reg reset", d, 0);
    end
    chk("R1 irq reset", {29'b0, irq, wr_wait, rd_wait}, 0);
    chk("R1 clk_force reset", {31'b0, clk_force}, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(3, 32'hFFFF_FFFF); rd(3, d);
    chk("R2 ctrl unused bits", d, 32'h7);
    chk("R11 all ctrl outputs", {29'b0, clk_force, rd_wait, wr_wait}, 32'h7);
    wr(3, 32'h2);
    chk("R11 read wait only", {29'b0, clk_force, rd_wait, wr_wait}, 32'h2);
    wr(3, 32'h5);
    chk("R11 write wait and clock", {29'b0, clk_force, rd_wait, wr_wait}, 32'h5);
    wr(3, 0);
  endtask

  task automatic t_watch_reg;
    logic [31:0] d;
    wr(4, 32'hFFFF_FFFF); rd(4, d); chk("R3 watch width", d, 32'h7FFF);
    wr(6, 32'hA5A5_1234); rd(6, d); chk("R3 watch port2", d, 32'h1234);
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R2 latch mask width", d, 32'h3F);
  endtask

  task automatic t_read_trig;
    logic [31:0] d;
    wr(1, 32'h3F);
    wr(4, {17'b0, 14'h123, 1'b0});
    access(0, 1, 1, 14'h123, 0); rd(0, d); chk("R4 write ignored on read select", d, 0);
    access(0, 1, 0, 14'h123, 0); rd(0, d); chk("R4 read hit port0", d, 32'h1);
    wr(0, 32'h3F);
  endtask

  task automatic t_write_trig;
    logic [31:0] d;
    wr(5, {17'b0, 14'h2AA, 1'b1});
    access(1, 1, 0, 14'h2AA, 0); rd(0, d); chk("R5 read ignored on write select", d, 0);
    access(1, 1, 1, 14'h2AA, 0); rd(0, d); chk("R5 write hit port1", d, 32'h2);
    wr(0, 32'h3F);
  endtask

  task automatic t_mismatch;
    logic [31:0] d;
    wr(6, {17'b0, 14'h3FFF, 1'b0});
    access(2, 1, 0, 14'h3FFE, 0); rd(0, d); chk("R6 address mismatch", d, 0);
    access(2, 0, 0, 14'h3FFF, 0); rd(0, d); chk("R6 no strobe", d, 0);
    access(2, 1, 0, 14'h3FFF, 0); rd(0, d); chk("R12 port2 only bit2", d, 32'h4);
    wr(0, 32'h3F);
  endtask

  task automatic t_err;
    logic [31:0] d;
    access(1, 0, 0, 0, 1); rd(0, d); chk("R7 port1 error bit4", d, 32'h10);
    @(negedge clk); acc_err = 3'b111; @(posedge clk); @(negedge clk); acc_err = 0;
    rd(0, d); chk("R7 all errors", d, 32'h38);
    wr(0, 32'h3F);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(1, 0);
    access(0, 1, 0, 14'h123, 1); rd(0, d); chk("R8 masked events", d, 0);
    wr(1, 32'h8);
    access(0, 1, 0, 14'h123, 1); rd(0, d); chk("R8 partial mask", d, 32'h8);
    wr(0, 32'h3F); wr(1, 32'h3F);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    @(negedge clk);
    acc_err = 3'b111; acc_valid = 3'b111;
    acc_write = 3'b010; acc_addr = {14'h3FFF, 14'h2AA, 14'h123};
    @(posedge clk); @(negedge clk); acc_err = 0; acc_valid = 0; acc_write = 0;
    rd(0, d); chk("R9 all set", d, 32'h3F);
    wr(0, 0); rd(0, d); chk("R9 zero write no effect", d, 32'h3F);
    wr(0, 32'h5); rd(0, d); chk("R9 one clears", d, 32'h3A);
    @(negedge clk);
    acc_err[0] = 1; reg_valid = 1; reg_write = 1; reg_addr = 0; reg_wdata = 32'h8;
    @(posedge clk); @(negedge clk); acc_err = 0; reg_valid = 0; reg_write = 0;
    rd(0, d); chk("R9 set wins over clear", d, 32'h3A);
  endtask

  task automatic t_irq;
    wr(2, 0);
    @(posedge clk); @(negedge clk);
    chk("R10 masked irq low", {31'b0, irq}, 0);
    wr(2, 32'h2);
    @(posedge clk); @(negedge clk);
    chk("R10 irq high", {31'b0, irq}, 1);
    wr(0, 32'h2);
    @(posedge clk); @(negedge clk);
    chk("R10 irq low after clear", {31'b0, irq}, 0);
    wr(0, 32'h3F); wr(2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_ctrl; t_watch_reg; t_read_trig; t_write_trig;
    t_mismatch; t_err; t_mask; t_w1c; t_irq;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule